// File: doc/BRIEF.md
# Memory-Mapped Down-Counting Interval Timer

This peripheral hangs on a simple synchronous 16-bit CPU register port and produces periodic interrupt requests. A programmable prescaler divides the system clock into timer ticks. Each tick decrements a 32-bit counter. On the tick that brings the counter to zero, an interrupt flag is raised. On the following tick, the counter reloads from a 32-bit period register. The flag drives the interrupt line whenever software has enabled it.

Software programs the period and the prescaler as pairs of halves, then runs or halts the timer through a control word. The same word can force an immediate reload and clear the flag. A period of zero produces no interrupts at all. Out of reset the timer is already running with an all-ones period, so software that never programs it still sees it counting.

Top module: `dn_timer`

## Requirements
- R1: Word map on `bus_addr_i`: 0 is count low, 1 is count high, 2 is period low, 3 is period high, 4 is control, 6 is prescale low byte, 7 is prescale high byte. Offset 5 reads as 0. The count halves are read-only: writes to offsets 0 and 1 leave the counter unchanged. Reads are combinational and show the live value.
- R2: The prescale value P is 16 bits. Its bits [7:0] are held in bits [7:0] of offset 6 and its bits [15:8] in bits [7:0] of offset 7. A running timer ticks once every P+1 clock cycles.
- R3: Each tick decrements a nonzero counter by one. A counter that already sits at zero is loaded with the period on the next tick. A period of N therefore gives one zero event every N+1 ticks.
- R4: The interrupt flag is control bit 15. It is set on the tick that takes the counter from 1 to 0. Writing 1 to bit 15 clears it. If a clear and a new zero event fall in the same cycle, the flag stays set.
- R5: Control bit 14 is the interrupt enable. `irq_o` is high exactly while both the flag and the enable are 1.
- R6: While control bit 4 (stop) is 1, the counter and the prescaler hold their values. While it is 0, the timer runs.
- R7: Writing 1 to control bit 5 copies the period into the counter at that clock edge and restarts the prescale count. This takes precedence over a tick in the same cycle. Bit 5 always reads as 0.
- R8: While the period is zero, the flag is never set, even if the counter passes through zero.
- R9: After reset, the period and the counter are 0xFFFF_FFFF, the prescale value is 0, and stop, enable and flag are 0. The counter starts decrementing on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Word address of the register |
| bus_we_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of prescale values 0 to 3 and periods 1 to 4. In every cycle it compares the live count and the interrupt line with a value worked out from tick arithmetic. This catches a reload that happens on the same tick as the zero instead of the tick after it, which would shorten every interval by one tick, and also catches an off-by-one in the prescale divide.

A prescale value of 256 checks that the high prescale byte takes effect. Further cases cover:
- a flag clear that lands on the same edge as a zero event, where a clear-wins design would lose an interrupt;
- a forced reload during a tick, where a wrong priority leaves the counter one below the period;
- a zero period, including one written while the counter is still nonzero, where a design gating on the counter alone would fire once;
- a stop that fails to freeze the count.

// File: rtl/dn_timer_pkg.sv
package dn_timer_pkg;
  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_PER_LO = 3'd2,
    A_PER_HI = 3'd3,
    A_CTRL   = 3'd4,
    A_RSVD   = 3'd5,
    A_PRE_LO = 3'd6,
    A_PRE_HI = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_STOP = 4;
  localparam int unsigned CTRL_LOAD = 5;
  localparam int unsigned CTRL_IE   = 14;
  localparam int unsigned CTRL_FLAG = 15;
endpackage

// File: rtl/dn_timer_prescaler.sv
module dn_timer_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] psc_q;

  assign tick_o = run_i && (psc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      psc_q <= '0;
    else if (load_i)  psc_q <= div_i;
    else if (run_i)   psc_q <= (psc_q == '0) ? div_i : psc_q - PRE_W'(1);
  end

  p_psc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(psc_q));
endmodule

// File: rtl/dn_timer_counter.sv
module dn_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o      = cnt_q;
  // counter about to reach zero on this tick; zero period never fires
  assign zero_evt_o = tick_i && !load_i && (cnt_q == CNT_W'(1)) && (period_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '1;
    else if (load_i)            cnt_q <= period_i;
    else if (tick_i) begin
      if (cnt_q == '0)          cnt_q <= period_i;
      else                      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_reload_next_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '0) |=> (cnt_q == $past(period_i)));
  p_force_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(period_i)));
  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dn_timer.sv
module dn_timer #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       bus_addr_i,
  input  logic             bus_we_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  import dn_timer_pkg::*;

  localparam int unsigned CNT_W = 2 * BUS_W;
  localparam int unsigned PRE_H = PRE_W / 2;

  logic [CNT_W-1:0] per_q;
  logic [PRE_H-1:0] pre_lo_q, pre_hi_q;
  logic             stop_q, ie_q, flag_q;
  logic [CNT_W-1:0] cnt;
  logic             tick, zero_evt;
  logic             wr_ctrl, load, clr;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata_i;

  assign wr_ctrl = bus_we_i && (bus_addr_i == A_CTRL);
  assign load    = wr_ctrl && bus_wdata_i[CTRL_LOAD];
  assign clr     = wr_ctrl && bus_wdata_i[CTRL_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q    <= '1;
      pre_lo_q <= '0;
      pre_hi_q <= '0;
      stop_q   <= 1'b0;
      ie_q     <= 1'b0;
    end else if (bus_we_i) begin
      case (bus_addr_i)
        A_PER_LO: per_q[BUS_W-1:0]     <= bus_wdata_i;
        A_PER_HI: per_q[CNT_W-1:BUS_W] <= bus_wdata_i;
        A_PRE_LO: pre_lo_q             <= bus_wdata_i[PRE_H-1:0];
        A_PRE_HI: pre_hi_q             <= bus_wdata_i[PRE_H-1:0];
        A_CTRL: begin
          stop_q <= bus_wdata_i[CTRL_STOP];
          ie_q   <= bus_wdata_i[CTRL_IE];
        end
        default: ;
      endcase
    end
  end

  // a new zero event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (zero_evt) flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

  assign irq_o = flag_q && ie_q;

  dn_timer_prescaler #(.PRE_W(PRE_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!stop_q),
    .load_i (load),
    .div_i  ({pre_hi_q, pre_lo_q}),
    .tick_o (tick)
  );

  dn_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .period_i   (per_q),
    .cnt_o      (cnt),
    .zero_evt_o (zero_evt)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CNT_LO: bus_rdata_o = cnt[BUS_W-1:0];
      A_CNT_HI: bus_rdata_o = cnt[CNT_W-1:BUS_W];
      A_PER_LO: bus_rdata_o = per_q[BUS_W-1:0];
      A_PER_HI: bus_rdata_o = per_q[CNT_W-1:BUS_W];
      A_CTRL: begin
        bus_rdata_o[CTRL_STOP] = stop_q;
        bus_rdata_o[CTRL_IE]   = ie_q;
        bus_rdata_o[CTRL_FLAG] = flag_q;
      end
      A_PRE_LO: bus_rdata_o[PRE_H-1:0] = pre_lo_q;
      A_PRE_HI: bus_rdata_o[PRE_H-1:0] = pre_hi_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  p_flag_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (cnt == '0));
  p_no_flag_zero_per_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == '0 && $past(per_q) == '0) |-> !$rose(flag_q));
  p_ctrl_load_reads0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_CTRL) |-> !bus_rdata_o[CTRL_LOAD]);
endmodule

// File: tb/dn_timer_bench.sv
module dn_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dn_timer u_dn_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic setup(input int pre, input logic [31:0] per);
    wr(3'd4, 16'h0010);
    wr(3'd6, 16'(pre & 8'hff));
    wr(3'd7, 16'((pre >> 8) & 8'hff));
    wr(3'd2, per[15:0]);
    wr(3'd3, per[31:16]);
    wr(3'd4, 16'h8030);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    int first;
    // R9 reset values
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R9 cnt_lo", v, 16'hffff);
    rd(3'd1, v); chk("R9 cnt_hi", v, 16'hffff);
    rd(3'd2, v); chk("R9 per_lo", v, 16'hffff);
    rd(3'd3, v); chk("R9 per_hi", v, 16'hffff);
    rd(3'd4, v); chk("R9 ctrl", v, 16'h0000);
    rd(3'd6, v); chk("R9 pre", v, 16'h0000);
    chk("R9 irq", irq, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R9 runs after reset lo", v, 16'hfffc);
    rd(3'd1, v); chk("R9 runs after reset hi", v, 16'hffff);

    // R2 R3 R4 R5 sweep
    for (int pre = 0; pre < 4; pre++) begin
      for (int per = 1; per < 5; per++) begin
        setup(pre, 32'(per));
        wr(3'd4, 16'h4000);
        for (int k = 0; k < 2 * (per + 1) * (pre + 1) + 3; k++) begin
          rd(3'd0, v);
          chk("R3 sweep count", v, 16'(per - ((k / (pre + 1)) % (per + 1))));
          chk("R5 sweep irq", irq, 32'(k >= per * (pre + 1)));
          @(negedge clk);
        end
      end
    end

    // R2 high prescale byte: P=256, period 1
    setup(256, 32'd1);
    rd(3'd7, v); chk("R2 pre_hi readback", v, 16'h0001);
    wr(3'd4, 16'h4000);
    first = -1;
    for (int k = 0; k < 400; k++) begin
      if (irq && first < 0) first = k;
      @(negedge clk);
    end
    chk("R2 first irq cycle", 32'(first), 32'd257);

    // R1 high halves and read-only count
    setup(0, 32'h0001_0002);
    rd(3'd0, v); chk("R1 cnt_lo", v, 16'h0002);
    rd(3'd1, v); chk("R1 cnt_hi", v, 16'h0001);
    wr(3'd0, 16'h1234);
    wr(3'd1, 16'h5678);
    rd(3'd0, v); chk("R1 cnt_lo ro", v, 16'h0002);
    rd(3'd1, v); chk("R1 cnt_hi ro", v, 16'h0001);
    rd(3'd5, v); chk("R1 offset5", v, 16'h0000);

    // R6 stop and R7 reload
    setup(1, 32'd100);
    wr(3'd4, 16'h0000);
    repeat (7) @(negedge clk);
    wr(3'd4, 16'h0010);
    rd(3'd0, v);
    repeat (10) @(negedge clk);
    rd(3'd0, v2);
    chk("R6 held", v2, v);
    chk("R6 ran before stop", 32'(v != 16'd100), 1);
    wr(3'd4, 16'h0030);
    rd(3'd0, v); chk("R7 reload stopped", v, 16'd100);
    rd(3'd4, v); chk("R7 load reads 0", v, 16'h0010);

    setup(0, 32'd50);
    wr(3'd4, 16'h0000);
    repeat (5) @(negedge clk);
    wr(3'd4, 16'h0020);
    rd(3'd0, v); chk("R7 reload beats tick", v, 16'd50);
    @(negedge clk);
    rd(3'd0, v); chk("R7 count after reload", v, 16'd49);

    // R5 enable gating
    setup(0, 32'd2);
    wr(3'd4, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R5 irq masked", irq, 0);
    rd(3'd4, v); chk("R4 flag visible", v, 16'h8000);
    wr(3'd4, 16'h4000);
    chk("R5 irq enabled", irq, 1);
    wr(3'd4, 16'h4010);
    wr(3'd4, 16'hc010);
    chk("R4 clear", irq, 0);

    // R4 set beats clear
    setup(0, 32'd1);
    wr(3'd4, 16'h4000);
    @(negedge clk);
    chk("R4 set at E1", irq, 1);
    wr(3'd4, 16'hc000);
    chk("R4 clear no event", irq, 0);
    wr(3'd4, 16'hc000);
    chk("R4 set wins over clear", irq, 1);
    wr(3'd4, 16'hc000);
    chk("R4 clear again", irq, 0);
    @(negedge clk);
    chk("R4 next set", irq, 1);

    // R8 zero period
    setup(0, 32'd0);
    wr(3'd4, 16'h4000);
    for (int k = 0; k < 40; k++) begin
      rd(3'd0, v);
      chk("R8 cnt stays 0", v, 0);
      chk("R8 no irq", irq, 0);
      @(negedge clk);
    end
    setup(0, 32'd5);
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h4000);
    for (int k = 0; k < 40; k++) begin
      chk("R8 no irq after passing zero", irq, 0);
      @(negedge clk);
    end
    rd(3'd4, v); chk("R8 flag clear", v, 16'h4000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule